// File: doc/BRIEF.md
# DMA Channel Interrupt Coalescing Register Block

This block is the control and status register file for one channel of a descriptor-driven DMA engine. Software starts and stops the channel, sets the next descriptor, and moves the tail descriptor through a 32-bit word-addressed register port. The descriptor engine sits beside this block. It receives a one-cycle start pulse whenever the tail pointer is written, and it returns a one-cycle pulse each time a packet finishes.

The block merges packet completions into fewer interrupts. A packet counter is loaded from a programmable threshold and counts down on each completion. When it reaches zero it raises the completion interrupt and reloads. An inactivity timer restarts on every completion when its timeout field is nonzero. When the timer runs out it raises the delay interrupt and reloads the packet counter. Each interrupt is cleared by writing 1 to it and is gated by its own enable bit. The live counter and timer values are returned in the upper half of the status word.

The timer counts in units of a parameterised prescaler. The prescaler phase restarts whenever the timer is reloaded, so a timeout of N lasts exactly N × PRESCALE clocks.

Top module: `dma_coal_regs`

## Requirements
- R1: After reset, control reads 0x0001_0000 and status reads 0x0001_0001 (halted in bit 0, counter = 1 in bits 23:16). The irq, run and start outputs are low, halted is high, and both descriptor registers read 0.
- R2: A control write (byte offset 0x00) stores the written word with bit 1 forced to 1. The run output follows control bit 0.
- R3: A control write with bit 0 = 1 and bit 2 = 0 clears halted (status bit 0) and idle (status bit 1). A control write with bit 0 = 0 leaves them unchanged.
- R4: A control write with bit 2 = 1 is a soft reset. Control becomes 0x0001_0000, status becomes 0x0001_0001, and the timer is cleared. This holds even when bit 0 is set in the same write. Bit 2 reads back as 0.
- R5: Each packet-done pulse decrements the counter modulo 256. A decrement from 1 sets status bit 12 and reloads the counter from control bits 23:16. With a threshold of 0, one pulse leaves the counter at 0xFF and bit 12 clear.
- R6: Every control write reloads the counter from the threshold being written.
- R7: A packet-done pulse with control bits 31:24 nonzero loads the timer with that value and restarts the prescaler. The timer then decrements once every PRESCALE clocks and stops at 0. The step from 1 to 0 sets status bit 13 and reloads the counter from the threshold.
- R8: A status read (byte offset 0x04) returns the live counter in bits 23:16 and the live timer in bits 31:24.
- R9: On a status write, bits 14:12 are cleared where the written bit is 1 and kept where it is 0. Status bits 15 and 11:0 take the written value.
- R10: irq is high exactly when some status bit in 14:12 is set together with the same-numbered control bit.
- R11: The current (0x08) and tail (0x10) descriptor registers store what is written. A tail write clears idle and drives start high for the one cycle after the write.
- R12: Any other offset, including offsets whose low two bits are nonzero, reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational, 0 when reg_rd is low |
| pkt_done | input | 1 | One-cycle packet completion pulse |
| irq | output | 1 | Level interrupt |
| run | output | 1 | Channel run bit |
| idle | output | 1 | Channel idle status |
| halted | output | 1 | Channel halted status |
| start | output | 1 | One-cycle pulse after a tail descriptor write |
| cur_desc | output | 32 | Current descriptor pointer |
| tail_desc | output | 32 | Tail descriptor pointer |

## Verification
The hardest condition to reach from the ports is the exact cycle in which the inactivity timer expires. At that edge the counter reload and the delay interrupt must land together, while the prescaler phase is not visible. Because a completion restarts the prescaler, the bench can issue one packet-done pulse and count clocks from that edge. It samples the status word one cycle before and one cycle after the computed expiry edge, and then again well after it to confirm the timer has stayed at zero.

// File: rtl/dma_coal_pkg.sv
// Package: register offsets, bit positions and reset values shared by the
// coalescing register block, its helpers and its checker.
package dma_coal_pkg;
    localparam int REG_W     = 32;
    localparam int CNT_W     = 8;
    localparam int TMR_W     = 8;

    // Byte offsets (word aligned).
    localparam int OFS_CTRL  = 'h00;
    localparam int OFS_STAT  = 'h04;
    localparam int OFS_CUR   = 'h08;
    localparam int OFS_TAIL  = 'h10;

    // Control bit positions.
    localparam int B_RUN      = 0;
    localparam int B_TAILMODE = 1;
    localparam int B_SRST     = 2;
    localparam int THR_LO     = 16;
    localparam int DLY_LO     = 24;

    // Status bit positions.
    localparam int B_HALT    = 0;
    localparam int B_IDLE    = 1;
    localparam int B_IOC     = 12;
    localparam int B_DLY     = 13;
    localparam int IRQ_LO    = 12;
    localparam int IRQ_HI    = 14;

    localparam logic [15:0]      IRQ_MASK = 16'h7000;
    localparam logic [REG_W-1:0] CTRL_RST = 32'h0001_0000;
    localparam logic [15:0]      STAT_RST = 16'h0001;
    localparam logic [CNT_W-1:0] THR_RST  = CNT_W'(1);

    typedef enum logic [2:0] {
        RS_NONE,
        RS_CTRL,
        RS_STAT,
        RS_CUR,
        RS_TAIL
    } reg_sel_e;
endpackage

// File: rtl/dma_coal_prescaler.sv
// Module: dma_coal_prescaler
// Produces a one-cycle tick every DIV clocks. A restart forces the phase
// back to zero, so the first tick after a restart comes DIV clocks later.
// Assumes DIV >= 1.
module dma_coal_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_every
            // Every clock is a tick; restart has no phase to reset.
            logic unused_restart;
            assign unused_restart = restart;
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] phase_q;

            // Phase counter, wraps at DIV-1, cleared by restart.
            always_ff @(posedge clk) begin
                if (!rst_n || restart) begin
                    phase_q <= '0;
                end else if (phase_q == LAST) begin
                    phase_q <= '0;
                end else begin
                    phase_q <= phase_q + 1'b1;
                end
            end

            assign tick = (phase_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/dma_coal_pkt_counter.sv
// Module: dma_coal_pkt_counter
// Packet completion counter. A configuration load wins over everything.
// Otherwise a timer expiry first reloads from the threshold, and a packet
// decrement then applies to that base value. Reaching zero raises hit and
// reloads from the threshold. Decrement from zero wraps modulo 2**W.
module dma_coal_pkt_counter #(
    parameter int W = 8,
    parameter logic [W-1:0] RST_VAL = W'(1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] thr,
    input  logic         expire,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         hit
);
    logic [W-1:0] cnt_q, base, dec_val, cnt_d;

    // Next-count selection and hit detection.
    always_comb begin
        base    = expire ? thr : cnt_q;
        dec_val = base - 1'b1;
        hit     = 1'b0;
        cnt_d   = base;
        if (load) begin
            cnt_d = load_val;
        end else if (dec) begin
            if (dec_val == '0) begin
                hit   = 1'b1;
                cnt_d = thr;
            end else begin
                cnt_d = dec_val;
            end
        end
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= RST_VAL;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/dma_coal_delay_timer.sv
// Module: dma_coal_delay_timer
// Inactivity timer. A packet with a nonzero timeout reloads it (and asks
// the prescaler to restart). A tick decrements a nonzero value. The step
// 1 -> 0 on a tick raises expire. A clear (soft reset) zeroes it.
module dma_coal_delay_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         pkt,
    input  logic [W-1:0] timeout,
    input  logic         tick,
    output logic [W-1:0] val,
    output logic         expire,
    output logic         restart
);
    logic [W-1:0] val_q;

    assign restart = !clr && pkt && (timeout != '0);
    assign expire  = !clr && !restart && tick && (val_q == W'(1));

    // Timer register: clear, reload, or count toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            val_q <= '0;
        end else if (restart) begin
            val_q <= timeout;
        end else if (tick && val_q != '0) begin
            val_q <= val_q - 1'b1;
        end
    end

    assign val = val_q;
endmodule

// File: rtl/dma_coal_regs.sv
// Module: dma_coal_regs
// Control/status register file for one DMA channel with interrupt
// coalescing. Single access port, one access per cycle, combinational
// read data with no read side effects. Assumes pkt_done is a one-cycle
// pulse from the descriptor engine.
module dma_coal_regs
    import dma_coal_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int PRESCALE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              pkt_done,
    output logic              irq,
    output logic              run,
    output logic              idle,
    output logic              halted,
    output logic              start,
    output logic [REG_W-1:0]  cur_desc,
    output logic [REG_W-1:0]  tail_desc
);
    localparam int WI_W = ADDR_W - 2;
    localparam logic [WI_W-1:0] WI_CTRL = WI_W'(OFS_CTRL / 4);
    localparam logic [WI_W-1:0] WI_STAT = WI_W'(OFS_STAT / 4);
    localparam logic [WI_W-1:0] WI_CUR  = WI_W'(OFS_CUR / 4);
    localparam logic [WI_W-1:0] WI_TAIL = WI_W'(OFS_TAIL / 4);

    reg_sel_e          sel;
    logic [WI_W-1:0]   word;
    logic              wr_ctrl, wr_stat, wr_cur, wr_tail, srst;
    logic [REG_W-1:0]  ctrl_q, cur_q, tail_q;
    logic [15:0]       stat_q, stat_d;
    logic              start_q;
    logic [CNT_W-1:0]  cnt_val, cnt_load_val;
    logic              cnt_hit;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_expire, tmr_restart, tick;

    assign word = reg_addr[ADDR_W-1:2];

    // Address decode; misaligned offsets select nothing.
    always_comb begin
        sel = RS_NONE;
        if (reg_addr[1:0] == 2'b00) begin
            if      (word == WI_CTRL) sel = RS_CTRL;
            else if (word == WI_STAT) sel = RS_STAT;
            else if (word == WI_CUR)  sel = RS_CUR;
            else if (word == WI_TAIL) sel = RS_TAIL;
        end
    end

    assign wr_ctrl = reg_wr && (sel == RS_CTRL);
    assign wr_stat = reg_wr && (sel == RS_STAT);
    assign wr_cur  = reg_wr && (sel == RS_CUR);
    assign wr_tail = reg_wr && (sel == RS_TAIL);
    assign srst    = wr_ctrl && reg_wdata[B_SRST];

    // Control register: soft reset restores defaults, else tail mode forced.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            ctrl_q <= CTRL_RST;
        end else if (wr_ctrl) begin
            ctrl_q <= reg_wdata | (REG_W'(1) << B_TAILMODE);
        end
    end

    // Next status: write with W1C interrupt field, run/tail side effects,
    // then hardware interrupt sets (set wins over a same-cycle clear).
    always_comb begin
        stat_d = stat_q;
        if (srst) begin
            stat_d = STAT_RST;
        end else begin
            if (wr_stat) begin
                stat_d = (reg_wdata[15:0] & ~IRQ_MASK) |
                         (stat_q & ~reg_wdata[15:0] & IRQ_MASK);
            end
            if (wr_ctrl && reg_wdata[B_RUN]) begin
                stat_d[B_HALT] = 1'b0;
                stat_d[B_IDLE] = 1'b0;
            end
            if (wr_tail) begin
                stat_d[B_IDLE] = 1'b0;
            end
        end
        if (cnt_hit)    stat_d[B_IOC] = 1'b1;
        if (tmr_expire) stat_d[B_DLY] = 1'b1;
    end

    // Status register.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= STAT_RST;
        else        stat_q <= stat_d;
    end

    // Descriptor pointers and the start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q   <= '0;
            tail_q  <= '0;
            start_q <= 1'b0;
        end else begin
            if (wr_cur)  cur_q  <= reg_wdata;
            if (wr_tail) tail_q <= reg_wdata;
            start_q <= wr_tail;
        end
    end

    assign cnt_load_val = srst ? THR_RST : reg_wdata[THR_LO +: CNT_W];

    dma_coal_prescaler #(.DIV(PRESCALE)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_restart),
        .tick    (tick)
    );

    dma_coal_pkt_counter #(.W(CNT_W), .RST_VAL(THR_RST)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_ctrl),
        .load_val (cnt_load_val),
        .thr      (ctrl_q[THR_LO +: CNT_W]),
        .expire   (tmr_expire),
        .dec      (pkt_done),
        .cnt      (cnt_val),
        .hit      (cnt_hit)
    );

    dma_coal_delay_timer #(.W(TMR_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (srst),
        .pkt     (pkt_done),
        .timeout (ctrl_q[DLY_LO +: TMR_W]),
        .tick    (tick),
        .val     (tmr_val),
        .expire  (tmr_expire),
        .restart (tmr_restart)
    );

    // Read multiplexer; status carries live counter and timer.
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            unique case (sel)
                RS_CTRL: reg_rdata = ctrl_q;
                RS_STAT: reg_rdata = {tmr_val, cnt_val, stat_q};
                RS_CUR:  reg_rdata = cur_q;
                RS_TAIL: reg_rdata = tail_q;
                default: reg_rdata = '0;
            endcase
        end
    end

    assign irq       = |(stat_q[IRQ_HI:IRQ_LO] & ctrl_q[IRQ_HI:IRQ_LO]);
    assign run       = ctrl_q[B_RUN];
    assign idle      = stat_q[B_IDLE];
    assign halted    = stat_q[B_HALT];
    assign start     = start_q;
    assign cur_desc  = cur_q;
    assign tail_desc = tail_q;
endmodule

// File: rtl/dma_coal_regs_chk.sv
// Module: dma_coal_regs_chk
// Temporal checks on the coalescing register block, attached by bind.
module dma_coal_regs_chk
    import dma_coal_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic              pkt_done,
    input logic              irq,
    input logic              run,
    input logic              idle,
    input logic              halted,
    input logic              start,
    input logic [REG_W-1:0]  ctrl_q,
    input logic [15:0]       stat_q,
    input logic [CNT_W-1:0]  cnt_val,
    input logic [TMR_W-1:0]  tmr_val
);
    logic ctrl_acc, tail_acc;
    assign ctrl_acc = reg_wr && (reg_addr == ADDR_W'(OFS_CTRL));
    assign tail_acc = reg_wr && (reg_addr == ADDR_W'(OFS_TAIL));

    // R3: a run write without soft reset leaves the channel active.
    p_run_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_acc && reg_wdata[B_RUN] && !reg_wdata[B_SRST]) |=> (!halted && !idle));

    // R4: soft reset halts the channel and drops run.
    p_soft_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_acc && reg_wdata[B_SRST]) |=> (halted && !run && cnt_val == CNT_W'(1)));

    // R5: the last counted packet raises the completion interrupt.
    p_ioc_on_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done && !reg_wr && cnt_val == CNT_W'(1) && tmr_val != TMR_W'(1))
        |=> stat_q[B_IOC]);

    // R7: an idle timer stays at zero until a packet arrives.
    p_timer_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_val == '0 && !pkt_done) |=> (tmr_val == '0));

    // R10: the interrupt needs an enabled source.
    p_irq_enabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ctrl_q[IRQ_HI:IRQ_LO] != 3'b000 && stat_q[IRQ_HI:IRQ_LO] != 3'b000));

    // R11: start is only ever the echo of a tail write.
    p_start_from_tail_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> $past(tail_acc));
endmodule

bind dma_coal_regs dma_coal_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .pkt_done  (pkt_done),
    .irq       (irq),
    .run       (run),
    .idle      (idle),
    .halted    (halted),
    .start     (start),
    .ctrl_q    (ctrl_q),
    .stat_q    (stat_q),
    .cnt_val   (cnt_val),
    .tmr_val   (tmr_val)
);

// File: tb/dma_coal_regs_test.sv
// Directed bench for dma_coal_regs: one task per scenario, each self-checking.
module dma_coal_regs_test;
    localparam int AW  = 6;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pkt_done = 1'b0;
    logic        irq, run, idle, halted, start;
    logic [31:0] cur_desc, tail_desc;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    dma_coal_regs #(.ADDR_W(AW), .PRESCALE(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pkt_done(pkt_done), .irq(irq), .run(run), .idle(idle),
        .halted(halted), .start(start), .cur_desc(cur_desc),
        .tail_desc(tail_desc)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // All access tasks start and end at a falling edge.
    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1;
        d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic pulse();
        pkt_done = 1'b1;
        @(negedge clk);
        pkt_done = 1'b0;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(6'h00, v); chk("R1 ctrl", v, 32'h0001_0000);
        rd(6'h04, v); chk("R1 status", v, 32'h0001_0001);
        rd(6'h08, v); chk("R1 cur", v, 32'h0);
        chk("R1 pins irq/run/halted/start", {28'h0, irq, run, halted, start}, 32'h2);
    endtask

    task automatic t_ctrl_write();
        logic [31:0] v;
        wr(6'h00, 32'h0000_0000);
        rd(6'h00, v); chk("R2 tail mode forced", v, 32'h0000_0002);
        chk("R3 run=0 keeps halted", {30'h0, run, halted}, 32'h1);
        rd(6'h04, v); chk("R6 reload to 0", v, 32'h0000_0001);
    endtask

    task automatic t_run();
        logic [31:0] v;
        wr(6'h04, 32'h0000_0003);
        chk("R9 halted/idle written", {30'h0, idle, halted}, 32'h3);
        wr(6'h00, 32'h0001_0001);
        chk("R3 run clears", {29'h0, run, idle, halted}, 32'h4);
        rd(6'h04, v); chk("R3 status", v, 32'h0001_0000);
    endtask

    task automatic t_count();
        logic [31:0] v;
        wr(6'h00, 32'h0003_1001);
        pulse(); rd(6'h04, v); chk("R5 count 2", v, 32'h0002_0000);
        pulse(); rd(6'h04, v); chk("R5 count 1", v, 32'h0001_0000);
        chk("R10 irq low", {31'h0, irq}, 32'h0);
        pulse(); rd(6'h04, v); chk("R5 hit and reload", v, 32'h0003_1000);
        chk("R10 irq high", {31'h0, irq}, 32'h1);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(6'h04, 32'h0000_0000);
        rd(6'h04, v); chk("R9 zero keeps irq bit", v, 32'h0003_1000);
        wr(6'h04, 32'h0000_1000);
        rd(6'h04, v); chk("R9 one clears", v, 32'h0003_0000);
        chk("R10 irq after clear", {31'h0, irq}, 32'h0);
        wr(6'h04, 32'h0000_8803);
        rd(6'h04, v); chk("R9 plain bits", v, 32'h0003_8803);
        wr(6'h04, 32'h0000_0000);
        // Masked source: bit set but enable off.
        wr(6'h00, 32'h0003_0001);
        pulse(); pulse(); pulse();
        chk("R10 masked", {31'h0, irq}, 32'h0);
        wr(6'h00, 32'h0003_1001);
        chk("R10 enable later", {31'h0, irq}, 32'h1);
        wr(6'h04, 32'h0000_7000);
    endtask

    task automatic t_reload();
        logic [31:0] v;
        wr(6'h00, 32'h0003_0001);
        pulse(); rd(6'h04, v); chk("R6 before", v, 32'h0002_0000);
        wr(6'h00, 32'h0003_0001);
        rd(6'h04, v); chk("R6 control write reloads", v, 32'h0003_0000);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        wr(6'h00, 32'h0000_0001);
        pulse(); rd(6'h04, v); chk("R5 zero threshold wraps", v, 32'h00FF_0000);
    endtask

    task automatic t_delay();
        logic [31:0] v;
        wr(6'h00, 32'h0305_2001);
        pulse(); rd(6'h04, v); chk("R8 live fields", v, 32'h0304_0000);
        cycles(3); rd(6'h04, v); chk("R7 held one period", v[31:24], 32'h3);
        cycles(1); rd(6'h04, v); chk("R7 prescaled step", v[31:24], 32'h2);
        cycles(7); rd(6'h04, v); chk("R7 before expiry", v, 32'h0104_0000);
        cycles(1); rd(6'h04, v); chk("R7 expiry", v, 32'h0005_2000);
        chk("R10 delay irq", {31'h0, irq}, 32'h1);
        cycles(20); rd(6'h04, v); chk("R7 stays zero", v, 32'h0005_2000);
        wr(6'h04, 32'h0000_2000);
    endtask

    task automatic t_soft_reset();
        logic [31:0] v;
        wr(6'h00, 32'h0A01_0001);
        pulse();
        wr(6'h00, 32'h0000_0005);
        rd(6'h00, v); chk("R4 ctrl", v, 32'h0001_0000);
        rd(6'h04, v); chk("R4 status", v, 32'h0001_0001);
        chk("R4 pins run/halted", {30'h0, run, halted}, 32'h1);
    endtask

    task automatic t_tail();
        logic [31:0] v;
        wr(6'h04, 32'h0000_0002);
        chk("R11 idle set", {31'h0, idle}, 32'h1);
        wr(6'h08, 32'h1234_5670);
        rd(6'h08, v); chk("R11 cur", v, 32'h1234_5670);
        chk("R11 cur pin", cur_desc, 32'h1234_5670);
        wr(6'h10, 32'hABCD_0040);
        chk("R11 start and idle", {30'h0, start, idle}, 32'h2);
        rd(6'h10, v); chk("R11 tail", v, 32'hABCD_0040);
        chk("R11 tail pin", tail_desc, 32'hABCD_0040);
        @(negedge clk);
        chk("R11 start one cycle", {31'h0, start}, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(6'h0C, 32'hFFFF_FFFF);
        wr(6'h05, 32'hFFFF_FFFF);
        rd(6'h0C, v); chk("R12 read gap", v, 32'h0);
        rd(6'h05, v); chk("R12 read misaligned", v, 32'h0);
        rd(6'h00, v); chk("R12 ctrl untouched", v, 32'h0001_0000);
        rd(6'h04, v); chk("R12 status untouched", v, 32'h0001_0000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl_write();
        t_run();
        t_count();
        t_w1c();
        t_reload();
        t_wrap();
        t_delay();
        t_soft_reset();
        t_tail();
        t_unmapped();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule